// File: doc/BRIEF.md
# Host Attachment Control Register Block

This block is the register set a host processor sees when it talks to a network adapter through a memory-mapped window. Every access carries its intent in the address. The low five bits pick a register. The next two bits pick an operation: plain store, AND-merge, OR-merge or read. The top two bits pick one of four areas. A single store can therefore clear or set chosen bits of a status register in one bus cycle, with no read-modify-write on the host side.

The block keeps three kinds of state:
- **Host-side interrupt status:** a byte with a master enable and a byte of adapter-posted events.
- **Doorbell byte:** the host rings it and the adapter core acknowledges it.
- **Configuration storage:** shared-memory relocation, timer and paging registers.

Single-cycle event pulses from the adapter core are merged into the status bits. The block drives one registered host interrupt line. A store that hits no register, or that targets a read-only identification area, raises an access-violation flag.

Top module: `host_ctl_regs`

## Requirements
- R1: The address is split as area = bits 8:7, operation = bits 6:5, register = bits 4:0. The operation codes are:
  - 00: store the data byte.
  - 01: AND the data byte into the register.
  - 10: OR the data byte into the register.
  - 11: read the register.
- R2: A read returns its data on `bus_rdata` combinationally, in the cycle the access is presented. The result depends on the area:
  - Area 01 (reserved) and unknown registers of area 00 read 0x00.
  - Area 10 reads `ID_BASE` plus the register number.
  - Area 11 reads 0xAA for odd register numbers and 0x55 for even ones.
- R3: The host status register at 0x08 has this layout:
  - Bit 6 is the interrupt enable.
  - Bit 4 is timer expired, bit 3 is internal fault, bit 2 is access violation.
  - Bit 0 reads the `alt_sel_i` strap and cannot be written.
  - All other bits read 0.
- R4: Register 0x09 holds adapter events in bits 6 to 2. Bit i of `evt_odd_i` sets bit i of the register, and input bits outside 6..2 are ignored. Likewise, `evt_even_i` bits 4 and 3 set the same bits of 0x08.
- R5: An event pulse that arrives in the same cycle as a host AND-clear of the same bit leaves the bit set.
- R6: Register 0x0B holds six doorbell bits (5..0), which are also driven on `door_o`. A 1 on `door_ack_i` bit i clears doorbell bit i. If a host operation on 0x0B happens in the same cycle, it is applied after the acknowledge.
- R7: The interrupt line is registered: it changes one cycle after the status and enable bits change. It stays low while the enable bit is 0.
- R8: With the enable bit at 1, the interrupt line is high if any of these status bits is set: 0x08 bits 4..2 or 0x09 bits 6..2. It is low if none is set.
- R9: The access-violation bit is set in two cases:
  - A store or merge in area 00 to a register number that does not exist.
  - Any store or merge to area 10 or 11.
  Stores to area 01 change no register and do not raise the flag.
- R10: Relocation:
  - Register 0x00 keeps bits 7..1, and `ram_base_o` equals those bits (base address bits 19..13).
  - Register 0x01 is read-only. It reads the size code `ram_size_i` in bits 3:2 (00 = 8K, 01 = 16K, 10 = 32K, 11 = 64K).
  - A store to 0x01 is legal and changes nothing.
- R11: Registers 0x0C to 0x0F are byte storage for timer control and value. Register 0x18 is the paging register, and `page_en_o` is 1 exactly when its bits 7 and 6 are both 1 (as after a store of 0xC0).
- R12: Synchronous active-high reset clears all stored bits and the interrupt line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access strobe for this cycle |
| bus_addr | input | 9 | Area, operation and register fields |
| bus_wdata | input | 8 | Store or merge byte |
| bus_rdata | output | 8 | Read data, combinational |
| evt_even_i | input | 8 | Event pulses aligned to register 0x08 bits |
| evt_odd_i | input | 8 | Event pulses aligned to register 0x09 bits |
| door_ack_i | input | 6 | Doorbell acknowledge pulses |
| alt_sel_i | input | 1 | Primary (0) or alternate (1) adapter strap |
| ram_size_i | input | 2 | Shared memory size code |
| door_o | output | 6 | Doorbell bits |
| ram_base_o | output | 7 | Shared memory base bits 19..13 |
| page_en_o | output | 1 | Paging enabled |
| host_irq_o | output | 1 | Host interrupt line |

## Verification
The bench places an event pulse in the same cycle as an AND-clear. A design that let the host win would lose an adapter event. It also places a doorbell acknowledge beside an OR-set of the same bit; a design with the opposite ordering would drop the new ring. The interrupt line is sampled in the very cycle the status changes and again one cycle later, so a combinational or two-cycle path is caught. Stores to the reserved area and to the identification areas are checked for the flag: a decoder that flags the first or misses the second would show a wrong bit 2 on the next read.

// File: rtl/hcr_pkg.sv
package hcr_pkg;
    localparam int DW       = 8;
    localparam int SEL_W    = 5;
    localparam int ADDR_W   = 9;
    localparam int TMR_BASE = 12;

    localparam logic [SEL_W-1:0] SEL_RELOC_E = 5'h00;
    localparam logic [SEL_W-1:0] SEL_RELOC_O = 5'h01;
    localparam logic [SEL_W-1:0] SEL_HEVN    = 5'h08;
    localparam logic [SEL_W-1:0] SEL_HODD    = 5'h09;
    localparam logic [SEL_W-1:0] SEL_DOOR    = 5'h0B;
    localparam logic [SEL_W-1:0] SEL_PAGE    = 5'h18;

    localparam logic [DW-1:0] HEVN_STS  = 8'h1C;
    localparam logic [DW-1:0] HEVN_EVT  = 8'h18;
    localparam logic [DW-1:0] HEVN_KEEP = 8'h5C;
    localparam logic [DW-1:0] ACC_BIT   = 8'h04;
    localparam logic [DW-1:0] HODD_KEEP = 8'h7C;
    localparam logic [DW-1:0] DOOR_KEEP = 8'h3F;
    localparam logic [DW-1:0] RELOC_KEEP = 8'hFE;
    localparam int EN_POS = 6;

    typedef enum logic [1:0] {
        OP_STORE = 2'b00,
        OP_AND   = 2'b01,
        OP_OR    = 2'b10,
        OP_READ  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        AR_CTL  = 2'b00,
        AR_RSVD = 2'b01,
        AR_IDA  = 2'b10,
        AR_IDB  = 2'b11
    } area_e;

    typedef struct packed {
        logic reloc_e;
        logic reloc_o;
        logic hevn;
        logic hodd;
        logic door;
        logic tmr;
        logic page;
    } hit_t;
endpackage

// File: rtl/hcr_decode.sv
module hcr_decode
    import hcr_pkg::*;
#(
    parameter int TMR_REGS = 4,
    localparam int TIDX_W = (TMR_REGS > 1) ? $clog2(TMR_REGS) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output area_e             area,
    output op_e               op,
    output logic [SEL_W-1:0]  sel,
    output hit_t              hit,
    output logic              legal,
    output logic [TIDX_W-1:0] tmr_idx
);
    logic [SEL_W-1:0] tmr_off;

    always_comb begin
        area    = area_e'(addr[8:7]);
        op      = op_e'(addr[6:5]);
        sel     = addr[4:0];
        tmr_off = sel - SEL_W'(TMR_BASE);
        tmr_idx = tmr_off[TIDX_W-1:0];
        hit.reloc_e = (sel == SEL_RELOC_E);
        hit.reloc_o = (sel == SEL_RELOC_O);
        hit.hevn    = (sel == SEL_HEVN);
        hit.hodd    = (sel == SEL_HODD);
        hit.door    = (sel == SEL_DOOR);
        hit.page    = (sel == SEL_PAGE);
        hit.tmr     = (int'(sel) >= TMR_BASE) && (int'(sel) < TMR_BASE + TMR_REGS);
        legal       = |hit;
    end
endmodule

// File: rtl/hcr_rmw.sv
module hcr_rmw
    import hcr_pkg::*;
#(
    parameter int W = 8
) (
    input  op_e          op,
    input  logic         apply,
    input  logic [W-1:0] old_v,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] keep,
    input  logic [W-1:0] set_v,
    input  logic [W-1:0] clr_v,
    output logic [W-1:0] nxt
);
    logic [W-1:0] base_v;
    logic [W-1:0] res_v;

    always_comb begin
        base_v = old_v & ~clr_v;
        res_v  = base_v;
        if (apply) begin
            unique case (op)
                OP_STORE: res_v = wdata;
                OP_AND:   res_v = base_v & wdata;
                OP_OR:    res_v = base_v | wdata;
                default:  res_v = base_v;
            endcase
        end
        nxt = (res_v | set_v) & keep;
    end
endmodule

// File: rtl/hcr_irq.sv
module hcr_irq #(
    parameter int SW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [SW-1:0] sts,
    output logic          irq
);
    logic irq_d, irq_q;

    always_comb begin
        irq_d = en && (|sts);
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= irq_d;
    end

    assign irq = irq_q;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !en |=> !irq) else $error("irq while disabled"); // R7
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (rst)
        (en && |sts) |=> irq) else $error("irq not raised"); // R8
endmodule

// File: rtl/host_ctl_regs.sv
module host_ctl_regs
    import hcr_pkg::*;
#(
    parameter int          TMR_REGS = 4,
    parameter logic [7:0]  ID_BASE  = 8'hA0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_valid,
    input  logic [8:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] evt_even_i,
    input  logic [7:0] evt_odd_i,
    input  logic [5:0] door_ack_i,
    input  logic       alt_sel_i,
    input  logic [1:0] ram_size_i,
    output logic [5:0] door_o,
    output logic [6:0] ram_base_o,
    output logic       page_en_o,
    output logic       host_irq_o
);
    localparam int TIDX_W = (TMR_REGS > 1) ? $clog2(TMR_REGS) : 1;
    localparam int STS_W  = 8;

    typedef struct packed {
        logic [DW-1:0]               reloc;
        logic [DW-1:0]               hevn;
        logic [DW-1:0]               hodd;
        logic [DW-1:0]               door;
        logic [DW-1:0]               page;
        logic [TMR_REGS-1:0][DW-1:0] tmr;
    } regs_t;

    regs_t regs_d, regs_q;

    area_e             area;
    op_e               op;
    logic [SEL_W-1:0]  sel;
    hit_t              hit;
    logic              legal;
    logic [TIDX_W-1:0] tmr_idx;

    hcr_decode #(.TMR_REGS(TMR_REGS)) u_dec (
        .addr(bus_addr), .area(area), .op(op), .sel(sel),
        .hit(hit), .legal(legal), .tmr_idx(tmr_idx)
    );

    logic wr_act, ctl_wr, bad_wr, rd_act;
    always_comb begin
        wr_act = bus_valid && (op != OP_READ);
        rd_act = bus_valid && (op == OP_READ);
        ctl_wr = wr_act && (area == AR_CTL);
        bad_wr = (ctl_wr && !legal) ||
                 (wr_act && ((area == AR_IDA) || (area == AR_IDB)));
    end

    logic [DW-1:0] nx_reloc, nx_hevn, nx_hodd, nx_door, nx_page;
    logic [DW-1:0] hevn_set, door_clr;
    logic [TMR_REGS-1:0][DW-1:0] nx_tmr;

    always_comb begin
        hevn_set = (evt_even_i & HEVN_EVT) | (bad_wr ? ACC_BIT : 8'h00);
        door_clr = {2'b00, door_ack_i};
    end

    hcr_rmw #(.W(DW)) u_reloc (
        .op(op), .apply(ctl_wr && hit.reloc_e), .old_v(regs_q.reloc),
        .wdata(bus_wdata), .keep(RELOC_KEEP), .set_v('0), .clr_v('0), .nxt(nx_reloc)
    );
    hcr_rmw #(.W(DW)) u_hevn (
        .op(op), .apply(ctl_wr && hit.hevn), .old_v(regs_q.hevn),
        .wdata(bus_wdata), .keep(HEVN_KEEP), .set_v(hevn_set), .clr_v('0), .nxt(nx_hevn)
    );
    hcr_rmw #(.W(DW)) u_hodd (
        .op(op), .apply(ctl_wr && hit.hodd), .old_v(regs_q.hodd),
        .wdata(bus_wdata), .keep(HODD_KEEP), .set_v(evt_odd_i & HODD_KEEP),
        .clr_v('0), .nxt(nx_hodd)
    );
    hcr_rmw #(.W(DW)) u_door (
        .op(op), .apply(ctl_wr && hit.door), .old_v(regs_q.door),
        .wdata(bus_wdata), .keep(DOOR_KEEP), .set_v('0), .clr_v(door_clr), .nxt(nx_door)
    );
    hcr_rmw #(.W(DW)) u_page (
        .op(op), .apply(ctl_wr && hit.page), .old_v(regs_q.page),
        .wdata(bus_wdata), .keep(8'hFF), .set_v('0), .clr_v('0), .nxt(nx_page)
    );

    for (genvar g = 0; g < TMR_REGS; g++) begin : g_tmr
        hcr_rmw #(.W(DW)) u_tmr (
            .op(op), .apply(ctl_wr && hit.tmr && (tmr_idx == TIDX_W'(g))),
            .old_v(regs_q.tmr[g]), .wdata(bus_wdata), .keep(8'hFF),
            .set_v('0), .clr_v('0), .nxt(nx_tmr[g])
        );
    end

    always_comb begin
        regs_d       = regs_q;
        regs_d.reloc = nx_reloc;
        regs_d.hevn  = nx_hevn;
        regs_d.hodd  = nx_hodd;
        regs_d.door  = nx_door;
        regs_d.page  = nx_page;
        regs_d.tmr   = nx_tmr;
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    logic [DW-1:0] ctl_rd;
    always_comb begin
        ctl_rd = 8'h00;
        if (hit.reloc_e)      ctl_rd = regs_q.reloc;
        else if (hit.reloc_o) ctl_rd = {4'b0000, ram_size_i, 2'b00};
        else if (hit.hevn)    ctl_rd = regs_q.hevn | {7'b0, alt_sel_i};
        else if (hit.hodd)    ctl_rd = regs_q.hodd;
        else if (hit.door)    ctl_rd = regs_q.door;
        else if (hit.page)    ctl_rd = regs_q.page;
        else if (hit.tmr)     ctl_rd = regs_q.tmr[tmr_idx];
    end

    always_comb begin
        bus_rdata = 8'h00;
        if (rd_act) begin
            unique case (area)
                AR_CTL:  bus_rdata = ctl_rd;
                AR_IDA:  bus_rdata = ID_BASE + {3'b000, sel};
                AR_IDB:  bus_rdata = sel[0] ? 8'hAA : 8'h55;
                default: bus_rdata = 8'h00;
            endcase
        end
    end

    logic [STS_W-1:0] sts_vec;
    always_comb begin
        sts_vec = {regs_q.hodd[6:2], regs_q.hevn[4:2]};
    end

    hcr_irq #(.SW(STS_W)) u_irq (
        .clk(clk), .rst(rst), .en(regs_q.hevn[EN_POS]), .sts(sts_vec), .irq(host_irq_o)
    );

    assign door_o     = regs_q.door[5:0];
    assign ram_base_o = regs_q.reloc[7:1];
    assign page_en_o  = &regs_q.page[7:6];

    AST_BAD_WR_FLAG: assert property (@(posedge clk) disable iff (rst)
        bad_wr |=> regs_q.hevn[2]) else $error("flag missed"); // R9
    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && area == AR_RSVD) |=>
        $stable({regs_q.reloc, regs_q.page, regs_q.tmr, regs_q.door[5:0] | 6'h0,
                 regs_q.hevn[EN_POS], regs_q.hevn[2]}) || (|$past(door_ack_i)))
        else $error("reserved write changed state"); // R9
    AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
        evt_even_i[3] |=> regs_q.hevn[3]) else $error("event lost"); // R5
    AST_EVT_ODD: assert property (@(posedge clk) disable iff (rst)
        (|(evt_odd_i & HODD_KEEP)) |=>
        ((regs_q.hodd & $past(evt_odd_i & HODD_KEEP)) == $past(evt_odd_i & HODD_KEEP)))
        else $error("odd event lost"); // R4
    AST_ACK_CLR: assert property (@(posedge clk) disable iff (rst)
        ((|door_ack_i) && !(ctl_wr && hit.door)) |=>
        ((regs_q.door[5:0] & $past(door_ack_i)) == 6'b0))
        else $error("ack did not clear"); // R6
endmodule

// File: tb/tb_host_ctl_regs.sv
module tb_host_ctl_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_valid = 1'b0;
    logic [8:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] evt_even_i = '0;
    logic [7:0] evt_odd_i = '0;
    logic [5:0] door_ack_i = '0;
    logic       alt_sel_i = 1'b0;
    logic [1:0] ram_size_i = 2'b10;
    logic [5:0] door_o;
    logic [6:0] ram_base_o;
    logic       page_en_o;
    logic       host_irq_o;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    host_ctl_regs dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_even_i(evt_even_i),
        .evt_odd_i(evt_odd_i), .door_ack_i(door_ack_i), .alt_sel_i(alt_sel_i),
        .ram_size_i(ram_size_i), .door_o(door_o), .ram_base_o(ram_base_o),
        .page_en_o(page_en_o), .host_irq_o(host_irq_o)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [8:0] a, input logic [7:0] d,
                         input logic [7:0] ee, input logic [7:0] eo, input logic [5:0] ak);
        @(posedge clk); #1;
        bus_valid = v; bus_addr = a; bus_wdata = d;
        evt_even_i = ee; evt_odd_i = eo; door_ack_i = ak;
        @(posedge clk); #1;
        bus_valid = 1'b0; evt_even_i = '0; evt_odd_i = '0; door_ack_i = '0;
    endtask

    task automatic acc(input logic [8:0] a, input logic [7:0] d);
        drive(1'b1, a, d, 8'h00, 8'h00, 6'h00);
    endtask

    task automatic rd(input logic [8:0] a, input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        drive(1'b1, a, 8'h00, 8'h00, 8'h00, 6'h00);
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    // monitor: compare each read against the scoreboard queue
    always @(negedge clk) begin
        if (!rst && bus_valid && bus_addr[6:5] == 2'b11) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R2: unexpected read actual=%h expected=none", bus_rdata);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(10 * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R12 reset state
        chk("R12 irq", {7'b0, host_irq_o}, 8'h00);
        chk("R12 door", {2'b0, door_o}, 8'h00);
        chk("R12 page", {7'b0, page_en_o}, 8'h00);
        rd(9'h068, 8'h00, "R12 hevn");
        rd(9'h069, 8'h00, "R12 hodd");

        // R3 layout, R1 store
        acc(9'h008, 8'hFF);
        rd(9'h068, 8'h5C, "R3 store layout");
        tick();
        chk("R8 irq on", {7'b0, host_irq_o}, 8'h01);
        // R1 AND
        acc(9'h028, 8'h40);
        rd(9'h068, 8'h40, "R1 and");
        tick();
        chk("R8 irq off no status", {7'b0, host_irq_o}, 8'h00);
        // R1 OR
        acc(9'h049, 8'h24);
        rd(9'h069, 8'h24, "R1 or");
        acc(9'h009, 8'h00);
        rd(9'h069, 8'h00, "R1 store clear");

        // R5 event beats AND-clear
        acc(9'h048, 8'h08);
        drive(1'b1, 9'h028, 8'h40, 8'h08, 8'h00, 6'h00);
        rd(9'h068, 8'h48, "R5 event wins");
        acc(9'h028, 8'h40);
        rd(9'h068, 8'h40, "R5 and without event");

        // R4 odd events, out-of-range bits ignored
        drive(1'b0, 9'h000, 8'h00, 8'h00, 8'hFF, 6'h00);
        rd(9'h069, 8'h7C, "R4 odd events");
        acc(9'h009, 8'h00);
        drive(1'b0, 9'h000, 8'h00, 8'h10, 8'h00, 6'h00);
        rd(9'h068, 8'h50, "R4 timer event");
        acc(9'h008, 8'h40);

        // R7 registered irq timing, R8 raise
        tick(); tick();
        chk("R8 irq idle", {7'b0, host_irq_o}, 8'h00);
        drive(1'b0, 9'h000, 8'h00, 8'h00, 8'h40, 6'h00);
        chk("R7 irq one cycle late", {7'b0, host_irq_o}, 8'h00);
        tick();
        chk("R8 irq raised", {7'b0, host_irq_o}, 8'h01);
        acc(9'h028, 8'h00);
        tick(); tick();
        chk("R7 irq masked", {7'b0, host_irq_o}, 8'h00);
        rd(9'h069, 8'h40, "R7 status kept while masked");
        acc(9'h009, 8'h00);

        // R3 strap
        alt_sel_i = 1'b1;
        rd(9'h068, 8'h01, "R3 strap");
        acc(9'h008, 8'h01);
        rd(9'h068, 8'h01, "R3 strap not writable");
        alt_sel_i = 1'b0;
        acc(9'h008, 8'h00);

        // R6 doorbell
        acc(9'h04B, 8'h3F);
        chk("R6 door set", {2'b0, door_o}, 8'h3F);
        rd(9'h06B, 8'h3F, "R6 door read");
        drive(1'b0, 9'h000, 8'h00, 8'h00, 8'h00, 6'h21);
        chk("R6 ack clear", {2'b0, door_o}, 8'h1E);
        drive(1'b1, 9'h04B, 8'h01, 8'h00, 8'h00, 6'h01);
        chk("R6 host after ack", {2'b0, door_o}, 8'h1F);
        acc(9'h02B, 8'h00);
        chk("R6 and clear", {2'b0, door_o}, 8'h00);

        // R9 access violation
        acc(9'h005, 8'h12);
        rd(9'h068, 8'h04, "R9 bad reg flag");
        acc(9'h008, 8'h00);
        acc(9'h088, 8'hFF);
        rd(9'h068, 8'h00, "R9 reserved no flag");
        rd(9'h0E8, 8'h00, "R2 reserved read");
        acc(9'h108, 8'h00);
        rd(9'h068, 8'h04, "R9 id area flag");
        acc(9'h008, 8'h00);
        rd(9'h065, 8'h00, "R2 unknown reg read");
        rd(9'h163, 8'hA3, "R2 id area A");
        rd(9'h1E1, 8'hAA, "R2 id area B odd");
        rd(9'h1E0, 8'h55, "R2 id area B even");

        // R10 relocation
        acc(9'h000, 8'hA5);
        chk("R10 base", {1'b0, ram_base_o}, 8'h52);
        rd(9'h060, 8'hA4, "R10 reloc read");
        rd(9'h061, 8'h08, "R10 size code");
        acc(9'h001, 8'hFF);
        rd(9'h068, 8'h00, "R10 reloc odd store legal");
        rd(9'h061, 8'h08, "R10 size read-only");

        // R11 timer and paging
        for (int i = 0; i < 4; i++) acc(9'h00C + 9'(i), 8'h30 + 8'(i));
        for (int i = 0; i < 4; i++) rd(9'h06C + 9'(i), 8'h30 + 8'(i), "R11 timer store");
        acc(9'h018, 8'hC0);
        chk("R11 paging on", {7'b0, page_en_o}, 8'h01);
        rd(9'h078, 8'hC0, "R11 paging read");
        acc(9'h018, 8'h80);
        chk("R11 paging off", {7'b0, page_en_o}, 8'h00);

        // R12 mid-run reset
        acc(9'h04B, 8'h3F);
        acc(9'h008, 8'h44);
        tick(); tick();
        rst = 1'b1;
        tick(); tick();
        rst = 1'b0;
        chk("R12 door after reset", {2'b0, door_o}, 8'h00);
        chk("R12 base after reset", {1'b0, ram_base_o}, 8'h00);
        chk("R12 irq after reset", {7'b0, host_irq_o}, 8'h00);
        rd(9'h068, 8'h00, "R12 hevn after reset");
        rd(9'h06C, 8'h00, "R12 timer after reset");

        tick();
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R2: reads pending actual=%0d expected=0", exp_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule